// File: doc/BRIEF.md
# Serial Ones-Majority Detector

This block takes a word that arrives one bit per clock on a single data line and decides whether that word holds more ones than zeros, or exactly as many of each. It never collects the word into a parallel register. A small count of ones grows only on cycles where the incoming bit is 1, so the data bit acts as the count enable. A position sequencer follows the word from its leading bit to its final bit.

A marker input flags the cycle that carries the leading bit (the most significant bit of the word). On the clock edge that samples the final bit, the verdict is registered. It appears on the outputs together with a one-cycle valid strobe. The verdict flags then keep their value until the next word completes. Bits that arrive while no word is open are ignored. A marker that arrives before a word is complete drops the partial word and starts a new one. Words may follow each other with no idle cycle between them.

Top module: `serial_majority_det`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `res_valid`, `more_ones` and `tie` are all 0.
- R2: A word opens on the cycle where `word_start` is 1. That cycle carries the most significant bit. The remaining WORD_BITS-1 bits follow on consecutive cycles, with the least significant bit last.
- R3: `res_valid` is 1 for exactly one cycle: the cycle right after the edge that samples the final bit of a complete word. At all other times it is 0.
- R4: When `res_valid` is 1, `more_ones` is 1 if and only if the number of ones in the word is greater than WORD_BITS/2 (greater than 4 for 8-bit words).
- R5: When `res_valid` is 1, `tie` is 1 if and only if the number of ones equals WORD_BITS/2 (exactly 4 for 8-bit words). `more_ones` and `tie` are never both 1.
- R6: `more_ones` and `tie` change only on a cycle where `res_valid` is 1. Otherwise they hold the last verdict.
- R7: If `word_start` is 1 before a word has received all WORD_BITS bits, the partial word produces no strobe. That cycle is treated as the leading bit of a new word.
- R8: A new word whose `word_start` falls on the cycle right after the final bit of the previous word is counted in full, and both words produce a verdict.
- R9: Data bits sampled while no word is open produce no strobe and leave the flags unchanged.
- R10: The internal count of ones never exceeds WORD_BITS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Serial data bit for the current cycle |
| word_start | input | 1 | High on the cycle carrying the leading bit of a word |
| res_valid | output | 1 | One-cycle strobe marking a fresh verdict |
| more_ones | output | 1 | Last verdict: word held more ones than zeros |
| tie | output | 1 | Last verdict: word held equal ones and zeros |

## Verification
Suppose the position sequencer drifts by even one bit. Then the strobe lands one cycle off from the eighth bit after the marker, and the cycle-by-cycle comparison catches this on the first word. A count of ones that misses the first bit, keeps a stale value across an abort, or counts idle bits shows up as a wrong flag at the next strobe. Words with ones counts of 3, 4 and 5 separate the three outcomes at the threshold. A flag that moves between strobes is caught on the very cycle it changes, because the flags are compared on every clock.

// File: rtl/smd_pkg.sv
package smd_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RECV = 1'b1
  } seq_state_e;

  function automatic int unsigned cnt_width(input int unsigned bits);
    return $clog2(bits + 1);
  endfunction
endpackage

// File: rtl/smd_pos_seq.sv
// Tracks the bit position inside the current word and marks the final bit.
module smd_pos_seq
  import smd_pkg::*;
#(
  parameter int unsigned WORD_BITS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic word_start,
  output logic take,
  output logic last
);
  localparam int unsigned POS_W = (WORD_BITS > 1) ? $clog2(WORD_BITS) : 1;
  localparam logic [POS_W-1:0] LAST_IDX = POS_W'(WORD_BITS - 1);

  seq_state_e       state_q;
  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] idx;

  // A marker always restarts at index 0, whatever the sequencer was doing.
  always_comb begin
    idx  = word_start ? '0 : pos_q;
    take = word_start || (state_q == SEQ_RECV);
    last = take && (idx == LAST_IDX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      pos_q   <= '0;
    end else if (take) begin
      state_q <= last ? SEQ_IDLE : SEQ_RECV;
      pos_q   <= last ? '0 : idx + POS_W'(1);
    end
  end
endmodule

// File: rtl/smd_ones_cnt.sv
// Ones counter whose enable is the serial data bit itself.
module smd_ones_cnt
  import smd_pkg::*;
#(
  parameter int unsigned WORD_BITS = 8,
  localparam int unsigned CNT_W = cnt_width(WORD_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             take,
  input  logic             bit_in,
  output logic [CNT_W-1:0] cnt_next,
  output logic [CNT_W-1:0] cnt_q
);
  logic [CNT_W-1:0] base;
  logic             inc;

  always_comb begin
    base     = clear ? '0 : cnt_q;
    inc      = take && bit_in;
    cnt_next = base + CNT_W'(inc);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (clear || inc) begin
      cnt_q <= cnt_next;
    end
  end
endmodule

// File: rtl/smd_verdict.sv
// Registers the verdict when the final bit is sampled.
module smd_verdict
  import smd_pkg::*;
#(
  parameter int unsigned WORD_BITS = 8,
  localparam int unsigned CNT_W = cnt_width(WORD_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             done,
  input  logic [CNT_W-1:0] total,
  output logic             res_valid,
  output logic             more_ones,
  output logic             tie
);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(WORD_BITS / 2);

  logic more_d;
  logic tie_d;

  assign more_d = (total > HALF);

  // An equal split only exists for even word lengths.
  generate
    if (WORD_BITS % 2 == 0) begin : g_even
      assign tie_d = (total == HALF);
    end else begin : g_odd
      assign tie_d = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      more_ones <= 1'b0;
      tie       <= 1'b0;
    end else begin
      res_valid <= done;
      if (done) begin
        more_ones <= more_d;
        tie       <= tie_d;
      end
    end
  end
endmodule

// File: rtl/serial_majority_det.sv
module serial_majority_det
  import smd_pkg::*;
#(
  parameter int unsigned WORD_BITS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  input  logic word_start,
  output logic res_valid,
  output logic more_ones,
  output logic tie
);
  localparam int unsigned CNT_W = cnt_width(WORD_BITS);

  logic             take;
  logic             last;
  logic [CNT_W-1:0] ones_next;
  logic [CNT_W-1:0] ones_q;

  smd_pos_seq #(.WORD_BITS(WORD_BITS)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .word_start (word_start),
    .take       (take),
    .last       (last)
  );

  smd_ones_cnt #(.WORD_BITS(WORD_BITS)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .clear    (word_start),
    .take     (take),
    .bit_in   (bit_in),
    .cnt_next (ones_next),
    .cnt_q    (ones_q)
  );

  smd_verdict #(.WORD_BITS(WORD_BITS)) u_vrd (
    .clk       (clk),
    .rst       (rst),
    .done      (last),
    .total     (ones_next),
    .res_valid (res_valid),
    .more_ones (more_ones),
    .tie       (tie)
  );
endmodule

// File: rtl/smd_checker.sv
module smd_checker
  import smd_pkg::*;
#(
  parameter int unsigned WORD_BITS = 8,
  localparam int unsigned CNT_W = cnt_width(WORD_BITS)
) (
  input logic             clk,
  input logic             rst,
  input logic             word_start,
  input logic             res_valid,
  input logic             more_ones,
  input logic             tie,
  input logic [CNT_W-1:0] cnt
);
  localparam int unsigned AGE_W = $clog2(WORD_BITS + 2);
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(WORD_BITS + 1);

  // Cycles since the latest marker, saturating; 0 means none seen yet.
  logic [AGE_W-1:0] age_q;
  always_ff @(posedge clk) begin
    if (rst) age_q <= '0;
    else if (word_start) age_q <= AGE_W'(1);
    else if (age_q != '0 && age_q < AGE_MAX) age_q <= age_q + AGE_W'(1);
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!res_valid && !more_ones && !tie));

  // R3 / R7: a strobe lies exactly WORD_BITS cycles after the marker that opened it
  assert_strobe_timing_R3: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (age_q == AGE_W'(WORD_BITS)));

  assert_strobe_single_R3: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    !(more_ones && tie));

  assert_flags_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> $stable({more_ones, tie}));

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(WORD_BITS));
endmodule

bind serial_majority_det smd_checker #(.WORD_BITS(WORD_BITS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .word_start (word_start),
  .res_valid  (res_valid),
  .more_ones  (more_ones),
  .tie        (tie),
  .cnt        (ones_q)
);

// File: tb/serial_majority_det_tb.sv
`timescale 1ns/1ps
module serial_majority_det_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_in = 1'b0;
  logic word_start = 1'b0;
  logic res_valid, more_ones, tie;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;
  string phase = "R1 reset";

  // behavioural reference state
  int         m_pos = -1;
  logic [7:0] m_byte = '0;
  logic       e_valid = 1'b0, e_more = 1'b0, e_tie = 1'b0;

  always #2.5 clk = ~clk;

  serial_majority_det #(.WORD_BITS(8)) u_dut (
    .clk(clk), .rst(rst), .bit_in(bit_in), .word_start(word_start),
    .res_valid(res_valid), .more_ones(more_ones), .tie(tie)
  );

  task automatic check_bit(input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %b expected %b (t=%0t)", phase, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check_bit("R3 res_valid", res_valid, e_valid);
    check_bit("R4 more_ones", more_ones, e_more);
    check_bit("R5 tie", tie, e_tie);
  endtask

  task automatic apply(input logic ws, input logic b);
    @(negedge clk);
    word_start = ws;
    bit_in     = b;
    @(posedge clk);
    #1;
    e_valid = 1'b0;
    if (ws) begin
      m_pos  = 0;
      m_byte = '0;
    end
    if (m_pos >= 0) begin
      m_byte = {m_byte[6:0], b};
      m_pos++;
      if (m_pos == 8) begin
        e_valid = 1'b1;
        e_more  = ($countones(m_byte) > 4);
        e_tie   = ($countones(m_byte) == 4);
        m_pos   = -1;
      end
    end
    compare_all();
  endtask

  task automatic send_word(input logic [7:0] w, input int gap);
    for (int i = 7; i >= 0; i--) apply(i == 7, w[i]);
    for (int g = 0; g < gap; g++) apply(1'b0, 1'($urandom));
  endtask

  task automatic send_partial(input logic [7:0] w, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) apply(i == 7, w[i]);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    // R1: reset and first cycle after release
    repeat (3) @(posedge clk);
    #1;
    compare_all();
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    compare_all();

    // R9: bits with no open word are ignored
    phase = "R9 idle";
    for (int i = 0; i < 20; i++) apply(1'b0, 1'($urandom));

    // R2 R4 R5: directed counts around the threshold
    phase = "R4/R5 directed";
    send_word(8'h00, 2);
    send_word(8'hFF, 2);
    send_word(8'hF0, 1);   // 4 ones, tie
    send_word(8'h1F, 1);   // 5 ones
    send_word(8'h07, 1);   // 3 ones
    send_word(8'h0F, 1);   // tie
    send_word(8'h55, 0);
    send_word(8'hAB, 0);   // 5 ones
    phase = "R2 bit order";
    send_word(8'h80, 1);
    send_word(8'h01, 1);

    // R6: flags hold across idle bits after a verdict
    phase = "R6 hold";
    send_word(8'hFE, 0);
    for (int i = 0; i < 12; i++) apply(1'b0, 1'b1);
    send_word(8'h3C, 0);
    for (int i = 0; i < 12; i++) apply(1'b0, 1'b0);

    // R7: abort partial words at several depths, including the last bit slot
    phase = "R7 abort";
    send_partial(8'hFF, 5);
    send_word(8'h01, 1);
    send_partial(8'hFF, 7);
    send_word(8'h03, 1);
    send_partial(8'h00, 1);
    send_word(8'hF8, 1);

    // R8: back-to-back random words
    phase = "R8 back-to-back";
    for (int k = 0; k < 200; k++) send_word(8'($urandom), 0);

    // mixed random traffic with gaps and aborts
    phase = "R7/R8 random mix";
    for (int k = 0; k < 300; k++) begin
      if ($urandom_range(0, 5) == 0) send_partial(8'($urandom), $urandom_range(1, 7));
      send_word(8'($urandom), $urandom_range(0, 3));
    end

    finish_run();
  end
endmodule